// File: doc/BRIEF.md
# Secured Receive Frame Decryption Sequencer

This block controls what happens to a received radio frame once it has been stored. A byte stream from the receiver is written into a local frame buffer that the host can read. The first byte of the stream holds the frame length. The end of the frame is worked out from that length, so the receiver sends no end marker. The block then looks at the security-enable bit in the first frame-control octet. An unsecured frame raises the receive interrupt straight away. A secured frame raises the security interrupt instead. The block then stops taking new frames and waits for the host to decide what to do with it.

The host has two choices. It can set the ignore bit, which releases the frame unchanged, still in its encrypted form. Or it can load a 16-byte key, pick a 3-bit cipher suite and set the start bit. In that case the block sends a one-cycle start pulse to an external cipher engine and gives it the suite and key. It then waits for the engine's done pulse. When done arrives, the block raises the receive interrupt and keeps the authentication result in a status bit. Reading the interrupt status register returns both flags and clears them.

Top module: `secrx_decrypt_seq`

## Requirements
- R1: After reset, `irq`, `rx_busy` and `cip_start` are 0, and register 0x031 and register 0x02D both read as 0.
- R2: Accepted stream bytes are stored at buffer addresses from 0x300 upward, and the host reads them back at 0x300+i. The first byte is the length L, and only its low 7 bits count. The frame is complete when the byte at 0x300+L+2 has been stored.
- R3: When a frame completes and bit 3 of the byte at 0x301 is 0, bit 3 of register 0x031 is set and bit 4 stays 0.
- R4: When a frame completes and bit 3 of the byte at 0x301 is 1, bit 4 of register 0x031 is set and bit 3 is not set. `rx_busy` then goes high, and incoming stream bytes are dropped until the host decides.
- R5: Writing register 0x02C with bit 7 = 1 while a secured frame is held releases it. The write sets bit 3 of 0x031 and drops `rx_busy`, and the buffer is not changed. No `cip_start` is issued, even if bit 6 is also set in the same write.
- R6: Writing register 0x02C with bit 6 = 1 (and bit 7 = 0) while a secured frame is held has the following effect. `cip_start` is high for exactly the one cycle after the write. `cip_suite` equals bits 5:3 of that write. `cip_key` holds the bytes at 0x2B0..0x2BF, with the byte at 0x2B0 in bits 7:0.
- R7: Writing bit 6 of register 0x02C while no secured frame is held produces no `cip_start`.
- R8: A `cip_done` pulse during decryption has three effects. It sets bit 3 of 0x031, it drops `rx_busy`, and it loads bit 0 of register 0x02D with `cip_auth_fail`. A `cip_done` pulse at any other time is ignored.
- R9: Reading register 0x031 returns the flags as they were before the read and then clears both of them. If a flag is set in the same cycle as the read, the set wins.
- R10: Register 0x02C reads back the suite in bits 5:3, with bits 7 and 6 always reading 0. Key bytes read back at 0x2B0..0x2BF.
- R11: `irq` is high exactly when either interrupt flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Stream byte present |
| rx_data | input | 8 | Stream byte from the receiver |
| rx_busy | output | 1 | High while a secured frame is held or being decrypted; stream bytes are dropped |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 10 | Host register/buffer address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid the cycle after `host_re` |
| irq | output | 1 | OR of the interrupt flags |
| cip_start | output | 1 | One-cycle start pulse to the cipher engine |
| cip_suite | output | 3 | Selected cipher suite |
| cip_key | output | 128 | Decryption key, byte 0 in bits 7:0 |
| cip_done | input | 1 | Cipher engine completion pulse |
| cip_auth_fail | input | 1 | Authentication failed, valid with `cip_done` |

## Verification
The sequencer is exercised with an unsecured frame, a secured frame that is ignored, and two secured frames that are decrypted: one whose authentication fails and one whose authentication passes. Each of these paths leaves its own pattern in the interrupt flags, `rx_busy` and the start pulse. A start request sent while idle, and a write that sets ignore and start together, show whether start is accepted only in the right state and whether ignore takes priority. Stream bytes sent while a frame is held show whether the buffer is protected. A status read issued in the same cycle as a frame completion shows whether a set wins over a read-clear.

// File: rtl/secrx_pkg.sv
package secrx_pkg;
  localparam logic [9:0] ADDR_INTSTAT  = 10'h031;
  localparam logic [9:0] ADDR_SECCTL   = 10'h02C;
  localparam logic [9:0] ADDR_SECSTAT  = 10'h02D;
  localparam logic [9:0] ADDR_KEY_BASE = 10'h2B0;
  localparam logic [9:0] ADDR_BUF_BASE = 10'h300;
  localparam int KEY_BYTES     = 16;
  localparam int INT_SEC_BIT   = 4;
  localparam int INT_RX_BIT    = 3;
  localparam int CTL_IGN_BIT   = 7;
  localparam int CTL_GO_BIT    = 6;
  localparam int CTL_SUITE_LSB = 3;
  localparam int FC_SEC_BIT    = 3;

  typedef enum logic [1:0] {SQ_IDLE, SQ_HOLD, SQ_CRYPT} sq_state_t;

  // buffer index of the final (signal-strength) octet for a given length octet
  function automatic logic [7:0] last_index(input logic [6:0] len7);
    return {1'b0, len7} + 8'd2;
  endfunction

  // offset of a host address within the frame buffer window
  function automatic logic [9:0] buf_offset(input logic [9:0] addr);
    return addr - ADDR_BUF_BASE;
  endfunction
endpackage

// File: rtl/secrx_rx_store.sv
module secrx_rx_store
  import secrx_pkg::*;
#(
  parameter int BUF_DEPTH = 144,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_byte,
  output logic             buf_we,
  output logic             frame_done,
  output logic             frame_secured
);
  logic [7:0]       mem [BUF_DEPTH];
  logic [IDX_W-1:0] wr_idx;
  logic [6:0]       len_q;
  logic             sec_q;
  logic             at_last;

  assign buf_we        = accept & rx_valid;
  assign at_last       = (wr_idx != '0) && (int'(wr_idx) == int'(last_index(len_q)));
  assign frame_done    = buf_we & at_last;
  assign frame_secured = sec_q;
  assign rd_byte       = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (buf_we) mem[wr_idx] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      len_q  <= '0;
      sec_q  <= 1'b0;
    end else if (buf_we) begin
      if (wr_idx == '0) len_q <= rx_data[6:0];
      if (int'(wr_idx) == 1) sec_q <= rx_data[FC_SEC_BIT];
      if (at_last) wr_idx <= '0;
      else         wr_idx <= wr_idx + 1'b1;
    end
  end
endmodule

// File: rtl/secrx_regs.sv
module secrx_regs
  import secrx_pkg::*;
#(
  parameter int BUF_DEPTH = 144,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_re,
  input  logic [9:0]       host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic [7:0]       buf_byte,
  output logic [IDX_W-1:0] buf_idx,
  input  logic             rx_set,
  input  logic             sec_set,
  input  logic             fail_load,
  input  logic             fail_val,
  output logic             start_req,
  output logic             ignore_req,
  output logic             stat_read,
  output logic             flag_rx,
  output logic             flag_sec,
  output logic [2:0]       suite,
  output logic [8*KEY_BYTES-1:0] key_flat
);
  logic [7:0] key_q [KEY_BYTES];
  logic       fail_q;
  logic       ctl_wr, key_hit, buf_hit;
  logic [9:0] boff;
  logic [7:0] rmux;

  assign ctl_wr     = host_we && (host_addr == ADDR_SECCTL);
  assign start_req  = ctl_wr & host_wdata[CTL_GO_BIT];
  assign ignore_req = ctl_wr & host_wdata[CTL_IGN_BIT];
  assign stat_read  = host_re && (host_addr == ADDR_INTSTAT);
  assign key_hit    = (host_addr[9:4] == ADDR_KEY_BASE[9:4]);
  assign boff       = buf_offset(host_addr);
  assign buf_hit    = (host_addr >= ADDR_BUF_BASE) && (int'(boff) < BUF_DEPTH);
  assign buf_idx    = boff[IDX_W-1:0];

  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key
    assign key_flat[8*g +: 8] = key_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q[g] <= '0;
      else if (host_we && key_hit && (int'(host_addr[3:0]) == g)) key_q[g] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_rx  <= 1'b0;
      flag_sec <= 1'b0;
      fail_q   <= 1'b0;
      suite    <= '0;
    end else begin
      if (rx_set)         flag_rx  <= 1'b1;
      else if (stat_read) flag_rx  <= 1'b0;
      if (sec_set)        flag_sec <= 1'b1;
      else if (stat_read) flag_sec <= 1'b0;
      if (fail_load)      fail_q   <= fail_val;
      if (ctl_wr)         suite    <= host_wdata[CTL_SUITE_LSB +: 3];
    end
  end

  always_comb begin
    rmux = '0;
    if (host_addr == ADDR_INTSTAT) begin
      rmux[INT_SEC_BIT] = flag_sec;
      rmux[INT_RX_BIT]  = flag_rx;
    end else if (host_addr == ADDR_SECCTL) begin
      rmux[CTL_SUITE_LSB +: 3] = suite;
    end else if (host_addr == ADDR_SECSTAT) begin
      rmux[0] = fail_q;
    end else if (key_hit) begin
      rmux = key_q[host_addr[3:0]];
    end else if (buf_hit) begin
      rmux = buf_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_re) host_rdata <= rmux;
  end
endmodule

// File: rtl/secrx_seq.sv
module secrx_seq
  import secrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic frame_secured,
  input  logic start_req,
  input  logic ignore_req,
  input  logic cip_done,
  input  logic cip_auth_fail,
  output logic accept,
  output logic hold,
  output logic crypt,
  output logic cip_start,
  output logic rx_set,
  output logic sec_set,
  output logic fail_load,
  output logic fail_val
);
  sq_state_t state, state_nx;
  logic      go_now;

  assign hold      = (state == SQ_HOLD);
  assign crypt     = (state == SQ_CRYPT);
  assign accept    = (state == SQ_IDLE);
  assign go_now    = hold & start_req & ~ignore_req;
  assign sec_set   = accept & frame_done & frame_secured;
  assign fail_load = crypt & cip_done;
  assign fail_val  = cip_auth_fail;
  assign rx_set    = (accept & frame_done & ~frame_secured)
                   | (hold & ignore_req)
                   | fail_load;

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE:  if (sec_set) state_nx = SQ_HOLD;
      SQ_HOLD:  if (ignore_req) state_nx = SQ_IDLE;
                else if (start_req) state_nx = SQ_CRYPT;
      SQ_CRYPT: if (cip_done) state_nx = SQ_IDLE;
      default:  state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      cip_start <= 1'b0;
    end else begin
      state     <= state_nx;
      cip_start <= go_now;
    end
  end
endmodule

// File: rtl/secrx_decrypt_seq.sv
module secrx_decrypt_seq
  import secrx_pkg::*;
#(
  parameter int BUF_DEPTH = 144,
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [7:0]   rx_data,
  output logic         rx_busy,
  input  logic         host_we,
  input  logic         host_re,
  input  logic [9:0]   host_addr,
  input  logic [7:0]   host_wdata,
  output logic [7:0]   host_rdata,
  output logic         irq,
  output logic         cip_start,
  output logic [2:0]   cip_suite,
  output logic [127:0] cip_key,
  input  logic         cip_done,
  input  logic         cip_auth_fail
);
  logic             accept, st_hold, st_crypt;
  logic             ev_buf_we, ev_frame_done, frame_secured;
  logic             ev_start_req, ev_ignore_req, ev_stat_read;
  logic             ev_rx_set, ev_sec_set, fail_load, fail_val;
  logic             ev_ignore_take;
  logic             flag_rx, flag_sec;
  logic [IDX_W-1:0] buf_idx;
  logic [7:0]       buf_byte;

  assign rx_busy        = ~accept;
  assign irq            = flag_rx | flag_sec;
  assign ev_ignore_take = st_hold & ev_ignore_req;

  secrx_rx_store #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_idx(buf_idx), .rd_byte(buf_byte), .buf_we(ev_buf_we),
    .frame_done(ev_frame_done), .frame_secured(frame_secured)
  );

  secrx_regs #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .buf_byte(buf_byte), .buf_idx(buf_idx),
    .rx_set(ev_rx_set), .sec_set(ev_sec_set), .fail_load(fail_load), .fail_val(fail_val),
    .start_req(ev_start_req), .ignore_req(ev_ignore_req), .stat_read(ev_stat_read),
    .flag_rx(flag_rx), .flag_sec(flag_sec), .suite(cip_suite), .key_flat(cip_key)
  );

  secrx_seq seq_i (
    .clk(clk), .rst_n(rst_n), .frame_done(ev_frame_done), .frame_secured(frame_secured),
    .start_req(ev_start_req), .ignore_req(ev_ignore_req), .cip_done(cip_done),
    .cip_auth_fail(cip_auth_fail), .accept(accept), .hold(st_hold), .crypt(st_crypt),
    .cip_start(cip_start), .rx_set(ev_rx_set), .sec_set(ev_sec_set),
    .fail_load(fail_load), .fail_val(fail_val)
  );
endmodule

// File: rtl/secrx_chk.sv
module secrx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_busy,
  input logic irq,
  input logic cip_start,
  input logic cip_done,
  input logic st_hold,
  input logic st_crypt,
  input logic ev_buf_we,
  input logic ev_sec_set,
  input logic ev_rx_set,
  input logic ev_start_req,
  input logic ev_ignore_take,
  input logic ev_stat_read,
  input logic flag_rx,
  input logic flag_sec
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cip_start |=> !cip_start);                                            // R6
  AST_START_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cip_start) |-> $past(st_hold));                                 // R6
  AST_IDLE_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_req && !st_hold) |=> !cip_start);                           // R7
  AST_SECURED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sec_set |=> (rx_busy && irq && flag_sec));                         // R4
  AST_BUSY_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !ev_buf_we);                                              // R4
  AST_IGNORE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ignore_take |=> (!rx_busy && !cip_start && flag_rx));              // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_crypt && cip_done) |=> (!rx_busy && flag_rx));                    // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stat_read && !ev_rx_set && !ev_sec_set) |=> (!flag_rx && !flag_sec)); // R9
endmodule

bind secrx_decrypt_seq secrx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_busy(rx_busy), .irq(irq), .cip_start(cip_start),
  .cip_done(cip_done), .st_hold(st_hold), .st_crypt(st_crypt), .ev_buf_we(ev_buf_we),
  .ev_sec_set(ev_sec_set), .ev_rx_set(ev_rx_set), .ev_start_req(ev_start_req),
  .ev_ignore_take(ev_ignore_take), .ev_stat_read(ev_stat_read),
  .flag_rx(flag_rx), .flag_sec(flag_sec)
);

// File: tb/secrx_decrypt_seq_tb_top.sv
module secrx_decrypt_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_data = '0;
  logic         rx_busy;
  logic         host_we = 1'b0, host_re = 1'b0;
  logic [9:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         irq, cip_start;
  logic [2:0]   cip_suite;
  logic [127:0] cip_key;
  logic         cip_done = 1'b0, cip_auth_fail = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [127:0] exp_key;

  always #10 clk = ~clk;

  secrx_decrypt_seq dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_busy(rx_busy),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .cip_start(cip_start), .cip_suite(cip_suite),
    .cip_key(cip_key), .cip_done(cip_done), .cip_auth_fail(cip_auth_fail)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic host_read(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1'b1; host_addr = a;
    @(negedge clk); host_re = 1'b0; d = host_rdata;
  endtask

  // header of 3 octets, n payload octets, 2 check octets, quality, strength
  function automatic void make_frame(input bit sec, input int n, input logic [7:0] seed,
                                     output logic [7:0] f [$]);
    f = {};
    f.push_back(8'(3 + n + 2));
    f.push_back(sec ? 8'h49 : 8'h41);
    f.push_back(8'h88);
    f.push_back(seed);
    for (int i = 0; i < n; i++) f.push_back(seed + 8'(i) + 8'h10);
    f.push_back(8'hC1); f.push_back(8'hC2); f.push_back(8'h5A); f.push_back(8'hA5);
  endfunction

  task automatic send_bytes(input logic [7:0] f [$]);
    foreach (f[i]) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = f[i];
    end
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", irq, 0);
    check("R1 rx_busy", rx_busy, 0);
    check("R1 cip_start", cip_start, 0);
    host_read(10'h031, d); check("R1 int status", d, 0);
    host_read(10'h02D, d); check("R1 sec status", d, 0);
  endtask

  task automatic t_plain();
    logic [7:0] f [$];
    logic [7:0] d;
    make_frame(1'b0, 4, 8'h20, f);
    send_bytes(f);
    check("R3 busy low", rx_busy, 0);
    check("R11 irq high", irq, 1);
    host_read(10'h031, d); check("R3 rx flag only", d, 8'h08);
    check("R11 irq low after clear", irq, 0);
    host_read(10'h031, d); check("R9 cleared by read", d, 8'h00);
    host_read(10'h300, d); check("R2 length octet", d, f[0]);
    host_read(10'h305, d); check("R2 payload octet", d, f[5]);
    host_read(10'h300 + 10'(f[0]) + 10'd2, d); check("R2 last octet", d, 8'hA5);
  endtask

  task automatic t_ignore();
    logic [7:0] f [$];
    logic [7:0] g [$];
    logic [7:0] d;
    make_frame(1'b1, 2, 8'h40, f);
    send_bytes(f);
    check("R4 busy high", rx_busy, 1);
    host_read(10'h031, d); check("R4 sec flag only", d, 8'h10);
    make_frame(1'b0, 6, 8'h70, g);
    send_bytes(g);
    host_read(10'h300, d); check("R4 bytes dropped while held", d, f[0]);
    check("R4 no rx flag while held", irq, 0);
    host_write(10'h02C, 8'hC0 | 8'h10);
    check("R5 ignore beats start", cip_start, 0);
    check("R5 busy released", rx_busy, 0);
    @(negedge clk); check("R5 no late start", cip_start, 0);
    host_read(10'h031, d); check("R5 rx flag after ignore", d, 8'h08);
    host_read(10'h304, d); check("R5 buffer unchanged", d, f[4]);
  endtask

  task automatic t_idle_start();
    logic [7:0] d;
    host_write(10'h02C, 8'h40 | 8'h28);
    check("R7 no start while idle", cip_start, 0);
    @(negedge clk); check("R7 still no start", cip_start, 0);
    host_read(10'h02C, d); check("R10 ctl readback", d, 8'h28);
  endtask

  task automatic t_decrypt(input bit fail, input logic [2:0] s);
    logic [7:0] f [$];
    logic [7:0] d;
    make_frame(1'b1, 3, 8'h33, f);
    send_bytes(f);
    host_read(10'h031, d); check("R4 sec flag", d, 8'h10);
    host_write(10'h02C, 8'h40 | {2'b00, s, 3'b000});
    check("R6 start pulse", cip_start, 1);
    check("R6 suite", cip_suite, s);
    check("R6 key", cip_key, exp_key);
    @(negedge clk); check("R6 start one cycle", cip_start, 0);
    repeat (3) @(negedge clk);
    check("R6 busy during decrypt", rx_busy, 1);
    check("R8 no irq before done", irq, 0);
    cip_done = 1'b1; cip_auth_fail = fail;
    @(negedge clk); cip_done = 1'b0; cip_auth_fail = 1'b0;
    check("R8 busy released", rx_busy, 0);
    check("R11 irq after done", irq, 1);
    host_read(10'h031, d); check("R8 rx flag after done", d, 8'h08);
    host_read(10'h02D, d); check("R8 auth status", d, {7'd0, fail});
  endtask

  task automatic t_stray_done();
    logic [7:0] d;
    cip_done = 1'b1; cip_auth_fail = 1'b1;
    @(negedge clk); cip_done = 1'b0; cip_auth_fail = 1'b0;
    check("R8 stray done no irq", irq, 0);
    host_read(10'h02D, d); check("R8 stray done keeps status", d, 8'h00);
  endtask

  task automatic t_set_beats_clear();
    logic [7:0] f [$];
    logic [7:0] d;
    make_frame(1'b0, 1, 8'h55, f);
    for (int i = 0; i < f.size() - 1; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = f[i];
    end
    @(negedge clk); rx_valid = 1'b1; rx_data = f[f.size()-1]; host_re = 1'b1; host_addr = 10'h031;
    @(negedge clk); rx_valid = 1'b0; host_re = 1'b0;
    check("R9 read returns old flags", host_rdata, 8'h00);
    check("R9 set wins over clear", irq, 1);
    host_read(10'h031, d); check("R9 flag kept", d, 8'h08);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_ignore();
    t_idle_start();
    for (int i = 0; i < 16; i++) begin
      exp_key[8*i +: 8] = 8'h10 + 8'(3*i);
      host_write(10'h2B0 + 10'(i), 8'h10 + 8'(3*i));
    end
    host_read(10'h2B7, d); check("R10 key readback", d, 8'h10 + 8'd21);
    t_decrypt(1'b1, 3'd3);
    t_decrypt(1'b0, 3'd6);
    t_stray_done();
    t_set_beats_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule